// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system read and write an external asynchronous static RAM that holds 131,072 bytes. On the user side there is a simple request/ready handshake. It carries a 17-bit address, a write flag, a write byte and a read byte. On the memory side it drives the active-low chip-select, write-strobe and output-enable lines and the address bus. The byte bus is split into a drive value, a drive enable for the pad's tri-state buffer and a sampled input.

Each transfer runs as a fixed sequence of phases. Each phase is a whole number of clock cycles, derived from the clock period and the memory's timing figures in nanoseconds. The cycle count is the ceiling of the time divided by the period, and never less than one.

- A read holds chip select and output enable low for the access phase. It registers the byte on the last cycle of that phase.
- A write first presents the address and data with output enable high. It then pulses the write strobe low. The memory captures the byte when the write strobe rises.

Every strobe comes straight from a flip-flop. The controller's data driver is only on while output enable has been high for the current and the previous cycle, so the controller and the memory never drive the bus at the same time.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While rst_ni is low, all three strobes are high, the data driver is off and ready_o is low.
- R2: A read accepted at a clock edge sets chip select and output enable low, with the write strobe high, for exactly N_RD cycles starting the next cycle. N_RD = max(ceil(T_AA_NS/CLK_PERIOD_NS), ceil(T_OE_NS/CLK_PERIOD_NS)), at least 1.
- R3: The read byte is sampled from the bus on the last read cycle. It appears on rdata_o in the ready cycle and holds until the next read completes.
- R4: A write accepted at a clock edge gives one setup cycle with chip select low and the write strobe high. N_WP cycles with the write strobe low follow, where N_WP = max(ceil(T_WP_NS/CLK_PERIOD_NS), ceil(T_DW_NS/CLK_PERIOD_NS), ceil(T_AW_NS/CLK_PERIOD_NS)), at least 1. Output enable stays high for the whole write, and the write strobe is never low while chip select is high.
- R5: The address is constant while chip select stays low. The driven byte equals the request's write data and is constant while the driver stays on.
- R6: The data driver is on exactly during the write cycles (setup and pulse), and only when output enable is high in that cycle and the one before.
- R7: ready_o is high for one cycle, the cycle right after the last phase cycle of a transfer, with all strobes high.
- R8: A request is taken only in a cycle where the controller is idle. A request raised while a transfer runs is dropped and causes no memory access.
- R9: Phase lengths follow the ceiling rule with the parameters given. Different parameter sets give different read and write lengths.
- R10: Between transfers all strobes are high and the driver is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request, sampled only when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Byte address |
| wdata_i | input | 8 | Byte to write |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last byte read |
| sram_addr_o | output | 17 | Memory address bus |
| sram_ce_no | output | 1 | Memory chip select, active low |
| sram_we_no | output | 1 | Memory write strobe, active low |
| sram_oe_no | output | 1 | Memory output enable, active low |
| sram_dq_o | output | 8 | Byte driven onto the data bus |
| sram_dq_oe_o | output | 1 | Tri-state enable for the data bus driver |
| sram_dq_i | input | 8 | Byte sampled from the data bus |

## Verification
A request sampled at edge k shows its first phase cycle after edge k. A read's strobes are due in cycles k+1 through k+N_RD, and its ready pulse and data in cycle k+N_RD+1. A write's setup is due in cycle k+1, its write pulse in cycles k+2 through k+N_WP+1, and its ready pulse after that. The bench's model turns each accepted request into a queue of expected per-cycle values for exactly those cycles, computing N_RD and N_WP from its own parameters. It checks every output at each falling edge against the head of the queue. A memory model in the bench answers reads, so dropped requests and read-back data are seen only at the ports.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_RD       = 2'd1,
    ST_WR_SETUP = 2'd2,
    ST_WR_PULSE = 2'd3
  } sram_st_e;

  // ceiling of ns/period, never below one cycle
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_TIMER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
  import sram_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  sram_st_e st_nxt_i,
  output logic     ce_no,
  output logic     we_no,
  output logic     oe_no
);
  // strobes decoded from next state and registered: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_no <= 1'b1;
      we_no <= 1'b1;
      oe_no <= 1'b1;
    end else begin
      ce_no <= (st_nxt_i == ST_IDLE);
      we_no <= (st_nxt_i != ST_WR_PULSE);
      oe_no <= (st_nxt_i != ST_RD);
    end
  end

  AST_WE_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !ce_no); // R4
  AST_OE_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !oe_no)); // R4
endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wdata_ld_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          drv_nxt_i,
  input  logic          cap_i,
  input  logic [DW-1:0] dq_i,
  input  logic          oe_n_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      dq_oe_o <= drv_nxt_i;
      if (wdata_ld_i) dq_o    <= wdata_i;
      if (cap_i)      rdata_o <= dq_i;
    end
  end

  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (oe_n_i && $past(oe_n_i))); // R6
  AST_WDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && $past(dq_oe_o)) |-> $stable(dq_o)); // R5
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned AW            = 17,
  parameter int unsigned DW            = 8,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_AA_NS       = 10,
  parameter int unsigned T_OE_NS       = 3,
  parameter int unsigned T_WP_NS       = 7,
  parameter int unsigned T_DW_NS       = 5,
  parameter int unsigned T_AW_NS       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_ce_no,
  output logic          sram_we_no,
  output logic          sram_oe_no,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);
  localparam int unsigned N_RD = umax(ns_to_cycles(T_AA_NS, CLK_PERIOD_NS),
                                      ns_to_cycles(T_OE_NS, CLK_PERIOD_NS));
  localparam int unsigned N_WP = umax(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                      umax(ns_to_cycles(T_DW_NS, CLK_PERIOD_NS),
                                           ns_to_cycles(T_AW_NS, CLK_PERIOD_NS)));
  localparam int unsigned CNT_MAX = umax(N_RD, N_WP) - 1;
  localparam int unsigned CW = (CNT_MAX < 1) ? 1 : $clog2(CNT_MAX + 1);

  sram_st_e      st_q, st_nxt;
  logic          accept, fin, cap, tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;

  assign accept = (st_q == ST_IDLE) && req_i;

  always_comb begin
    st_nxt   = st_q;
    fin      = 1'b0;
    cap      = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        if (we_i) st_nxt = ST_WR_SETUP;
        else begin
          st_nxt   = ST_RD;
          tmr_load = 1'b1;
          tmr_val  = CW'(N_RD - 1);
        end
      end
      ST_RD: if (tmr_done) begin
        st_nxt = ST_IDLE;
        fin    = 1'b1;
        cap    = 1'b1;
      end
      ST_WR_SETUP: begin
        st_nxt   = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CW'(N_WP - 1);
      end
      ST_WR_PULSE: if (tmr_done) begin
        st_nxt = ST_IDLE;
        fin    = 1'b1;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ready_o     <= 1'b0;
      sram_addr_o <= '0;
    end else begin
      st_q    <= st_nxt;
      ready_o <= fin;
      if (accept) sram_addr_o <= addr_i;
    end
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_strobe_gen u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .st_nxt_i (st_nxt),
    .ce_no    (sram_ce_no),
    .we_no    (sram_we_no),
    .oe_no    (sram_oe_no)
  );

  sram_dq_path #(.DW(DW)) u_dq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wdata_ld_i (accept && we_i),
    .wdata_i    (wdata_i),
    .drv_nxt_i  (st_nxt == ST_WR_SETUP || st_nxt == ST_WR_PULSE),
    .cap_i      (cap),
    .dq_i       (sram_dq_i),
    .oe_n_i     (sram_oe_no),
    .dq_o       (sram_dq_o),
    .dq_oe_o    (sram_dq_oe_o),
    .rdata_o    (rdata_o)
  );

  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R7
  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_ce_no && sram_we_no && sram_oe_no)); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o)); // R5
  AST_WE_RISE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> ready_o); // R4
endmodule

// File: tb/sim_sram_seq_ctrl.sv
module sim_sram_seq_ctrl;
  localparam int unsigned PER    = 20;
  localparam int unsigned T_AA   = 45;
  localparam int unsigned T_OE   = 12;
  localparam int unsigned T_WP   = 30;
  localparam int unsigned T_DW   = 25;
  localparam int unsigned T_AWR  = 8;

  function automatic int cdiv(input int n, input int p);
    int c;
    c = (n + p - 1) / p;
    return (c < 1) ? 1 : c;
  endfunction

  // R9: expected phase lengths from the ceiling rule
  int n_rd, n_wp;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready;
  logic [7:0]  rdata;
  logic [16:0] m_addr;
  logic        ce_n, we_n, oe_n, dq_oe;
  logic [7:0]  dq_out;
  logic [7:0]  dq_in = '0;

  always #10 clk = ~clk;

  sram_seq_ctrl #(
    .CLK_PERIOD_NS(PER), .T_AA_NS(T_AA), .T_OE_NS(T_OE),
    .T_WP_NS(T_WP), .T_DW_NS(T_DW), .T_AW_NS(T_AWR)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .sram_addr_o(m_addr),
    .sram_ce_no(ce_n), .sram_we_no(we_n), .sram_oe_no(oe_n),
    .sram_dq_o(dq_out), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_in)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // memory device model
  logic [7:0] dev_mem [int];
  function automatic logic [7:0] dflt(input logic [16:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction
  always @(negedge clk) begin
    if (rst_n && !ce_n && !we_n && dq_oe) dev_mem[int'(m_addr)] = dq_out;
    if (rst_n && !ce_n && !oe_n && we_n)
      dq_in = dev_mem.exists(int'(m_addr)) ? dev_mem[int'(m_addr)] : dflt(m_addr);
    else
      dq_in = 8'h00;
  end

  // reference model
  typedef struct {
    logic ce, wen, oe, drv, rdy, ac, rc;
    logic [16:0] a;
    logic [7:0] d;
    logic [7:0] r;
  } exp_t;
  exp_t exp_q[$];
  logic [7:0] ref_mem [int];
  logic [7:0] last_rd = 8'h00;

  function automatic exp_t idle_e();
    exp_t e;
    e.ce = 1; e.wen = 1; e.oe = 1; e.drv = 0; e.rdy = 0; e.ac = 0; e.rc = 0;
    e.a = '0; e.d = '0; e.r = '0;
    return e;
  endfunction

  task automatic chk(input string tag, input string what, input logic [16:0] act, input logic [16:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic push_op(input logic w, input logic [16:0] a, input logic [7:0] d);
    exp_t e;
    if (w) begin
      e = idle_e(); e.ce = 0; e.drv = 1; e.ac = 1; e.a = a; e.d = d;
      exp_q.push_back(e);
      for (int i = 0; i < n_wp; i++) begin
        e.wen = 0;
        exp_q.push_back(e);
      end
      ref_mem[int'(a)] = d;
      e = idle_e(); e.rdy = 1; e.rc = 1; e.r = last_rd;
      exp_q.push_back(e);
    end else begin
      e = idle_e(); e.ce = 0; e.oe = 0; e.ac = 1; e.a = a;
      for (int i = 0; i < n_rd; i++) exp_q.push_back(e);
      last_rd = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : dflt(a);
      e = idle_e(); e.rdy = 1; e.rc = 1; e.r = last_rd;
      exp_q.push_back(e);
    end
  endtask

  // one cycle: check this cycle's outputs, then drive inputs for the next edge
  task automatic step(input logic rq, input logic w, input logic [16:0] a, input logic [7:0] d);
    exp_t e;
    bit idle_now;
    @(negedge clk);
    e = (exp_q.size() != 0) ? exp_q.pop_front() : idle_e();
    idle_now = e.ce;
    chk(e.ce ? "R10" : (e.oe ? "R4" : "R2"), "ce_n", 17'(ce_n), 17'(e.ce));
    chk(e.oe ? "R4" : "R2", "we_n", 17'(we_n), 17'(e.wen));
    chk(e.ce ? "R10" : "R2", "oe_n", 17'(oe_n), 17'(e.oe));
    chk("R6", "dq_oe", 17'(dq_oe), 17'(e.drv));
    chk("R7", "ready", 17'(ready), 17'(e.rdy));
    if (e.ac) chk("R5", "addr", m_addr, e.a);
    if (e.drv) chk("R5", "dq_o", 17'(dq_out), 17'(e.d));
    if (e.rc) chk("R3", "rdata", 17'(rdata), 17'(e.r));
    req = rq; we = w; addr = a; wdata = d;
    // R8: the model takes a request only in an idle cycle
    if (idle_now && rq) push_op(w, a, d);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) step(0, 0, '0, '0);
    step(0, 0, '0, '0);
  endtask

  initial begin
    n_rd = (cdiv(T_AA, PER) > cdiv(T_OE, PER)) ? cdiv(T_AA, PER) : cdiv(T_OE, PER);
    n_wp = cdiv(T_WP, PER);
    if (cdiv(T_DW, PER) > n_wp) n_wp = cdiv(T_DW, PER);
    if (cdiv(T_AWR, PER) > n_wp) n_wp = cdiv(T_AWR, PER);

    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "ce_n", 17'(ce_n), 17'd1);
    chk("R1", "we_n", 17'(we_n), 17'd1);
    chk("R1", "oe_n", 17'(oe_n), 17'd1);
    chk("R1", "dq_oe", 17'(dq_oe), 17'd0);
    chk("R1", "ready", 17'(ready), 17'd0);
    rst_n = 1'b1;
    repeat (2) step(0, 0, '0, '0);

    // R2 R3: read of an unwritten location
    step(1, 0, 17'h00010, 8'h00); step(0, 0, '0, '0); drain();
    // R4: writes at both address extremes, then read back
    step(1, 1, 17'h1FFFF, 8'h3C); drain();
    step(1, 0, 17'h1FFFF, 8'h00); drain();
    step(1, 1, 17'h00000, 8'hC3); drain();
    step(1, 0, 17'h00000, 8'h00); drain();

    // R8: write request pulsed while a read runs is dropped
    step(1, 0, 17'h00123, 8'h00);
    step(1, 1, 17'h00123, 8'hEE);
    step(0, 0, '0, '0);
    drain();
    step(1, 0, 17'h00123, 8'h00); drain(); // must return the default byte

    // R7: request held high, back-to-back transfers
    for (int i = 0; i < 14; i++) step(1, 1, 17'h00456, 8'h77);
    drain();
    for (int i = 0; i < 10; i++) step(1, 0, 17'h00456, 8'h00);
    drain();

    // mixed pseudo-random traffic
    begin
      logic [31:0] lf = 32'h1234_5678;
      for (int i = 0; i < 400; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        step(lf[3] | lf[7], lf[5], {13'h0, lf[12:9]}, lf[23:16]);
      end
    end
    drain();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 50000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule